// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block multiplies two unsigned 4-bit operands over several clocks and returns an 8-bit product. It holds one 9-bit working register. At the start the multiplier is written into the low half of that register. The high part holds the running partial product, and its top bit holds the adder carry. The multiplicand is added into the high part only when the bit at the bottom of the register is 1. After each bit is examined the whole register moves one place to the right. Because of this right shift, one operand-wide adder is enough and no double-width adder is needed.

A small four-state controller sequences the load, add and shift steps. A two-bit shift counter signals the last shift, so the controller does not need one state per multiplier bit. When the fourth shift is done, the controller raises a done flag for exactly one clock and then returns to idle. While done is high, the product output holds the finished result. The multiplicand input must stay stable from the start request until done.

Top module: `shift_add_mult`

## Requirements
- R1: While reset is active, and after reset until the first start, `done` is 0 and `product` is 0.
- R2: When `start` is 1 in idle, the register is loaded on the next edge. Bits 8..4 are cleared and bits 3..0 take `mplier`, so `product` then shows `{4'b0000, mplier}`.
- R3: When the bit in register position 0 is 1, the multiplicand plus register bits 7..4 (a 5-bit sum) is written into bits 8..4. The next cycle is always a shift. An add and a shift never happen in the same cycle.
- R4: When the bit in register position 0 is 0, no add takes place. All 9 bits shift right by one, and a 0 enters bit 8.
- R5: Exactly four shifts happen per operation. The shift counter is cleared on load, and the fourth shift ends the sequence.
- R6: `done` is high for exactly one cycle and then the block returns to idle. A `start` that arrives while an operation is running has no effect on that operation.
- R7: When `done` is high, `product` equals `mcand * mplier` for every one of the 256 operand pairs.
- R8: If the load edge counts as edge 1, `done` is first seen after edge 5 + (number of 1 bits in `mplier`). This gives 5 cycles at best and 9 at worst.
- R9: For mcand=1101 and mplier=1011, `product` shows 00001011, 11011011, 01101101, 00111101, 10011110, 01001111, 00011111 and 10001111 after successive edges. `done` is high only with the last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Request to begin a multiply; sampled only in idle |
| mcand | input | 4 | Multiplicand, held stable until done |
| mplier | input | 4 | Multiplier, sampled at load |
| product | output | 8 | Low 8 bits of the working register; the result while done is high |
| done | output | 1 | One-cycle completion flag |

## Verification
The hardest case to reach from the ports is a `start` that arrives in the middle of a multiply. The controller must ignore it, and this can only be seen through unchanged latency and an unchanged result. To cover it, the bench raises `start` again two cycles after the load and holds it for several cycles, which covers both the add state and the shift state. It then checks that `done` still arrives on the cycle that R8 predicts and that the product is still correct. The bench also drives every operand pair through the block. For each pair it predicts the finish cycle from the number of 1 bits in the multiplier, so a missing or extra add or shift changes the latency and is detected.

// File: rtl/sam_pkg.sv
package sam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEST  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } sam_state_e;
endpackage

// File: rtl/sam_rst_sync.sv
module sam_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sam_counter.sv
module sam_counter #(
  parameter int OP_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int CW = (OP_W > 1) ? $clog2(OP_W) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last_o = (cnt_q == CW'(OP_W - 1));

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              add_i,
  input  logic              shift_i,
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic              lsb_o,
  output logic [2*OP_W-1:0] low_o
);
  localparam int AW = 2 * OP_W + 1;

  logic [AW-1:0] acc_q, acc_d;
  logic [OP_W:0] sum;
  logic          acc_en;

  assign sum    = {1'b0, acc_q[AW-2:OP_W]} + {1'b0, mcand_i};
  assign acc_en = load_i | add_i | shift_i;

  always_comb begin
    acc_d = acc_q;
    if (load_i)       acc_d = {{(OP_W+1){1'b0}}, mplier_i};
    else if (add_i)   acc_d = {sum, acc_q[OP_W-1:0]};
    else if (shift_i) acc_d = {1'b0, acc_q[AW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign lsb_o = acc_q[0];
  assign low_o = acc_q[2*OP_W-1:0];

  AST_SHIFT_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> (acc_q[AW-1] == 1'b0)); // R4
  AST_LOW_KEPT_ON_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !load_i) |=> (acc_q[OP_W-1:0] == $past(acc_q[OP_W-1:0]))); // R3
endmodule

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import sam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic m_i,
  input  logic last_i,
  output logic load_o,
  output logic add_o,
  output logic shift_o,
  output logic done_o
);
  sam_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    add_o   = 1'b0;
    shift_o = 1'b0;
    done_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          state_d = ST_TEST;
        end
      end
      ST_TEST: begin
        if (m_i) begin
          add_o   = 1'b1;
          state_d = ST_SHIFT;
        end else begin
          shift_o = 1'b1;
          state_d = last_i ? ST_DONE : ST_TEST;
        end
      end
      ST_SHIFT: begin
        shift_o = 1'b1;
        state_d = last_i ? ST_DONE : ST_TEST;
      end
      ST_DONE: begin
        done_o  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  AST_ADD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_o && shift_o)); // R3
  AST_ADD_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    add_o |=> shift_o); // R3
  AST_LAST_SHIFT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_o && last_i) |=> done_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (add_o || shift_o) |=> !load_o); // R6
endmodule

// File: rtl/shift_add_mult.sv
module shift_add_mult #(
  parameter int OP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   mcand,
  input  logic [OP_W-1:0]   mplier,
  output logic [2*OP_W-1:0] product,
  output logic              done
);
  logic rst_n_int;
  logic load, add, shift, m_bit, last;

  sam_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sam_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start),
    .m_i     (m_bit),
    .last_i  (last),
    .load_o  (load),
    .add_o   (add),
    .shift_o (shift),
    .done_o  (done)
  );

  sam_counter #(.OP_W(OP_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .clr_i  (load),
    .inc_i  (shift),
    .last_o (last)
  );

  sam_datapath #(.OP_W(OP_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load_i   (load),
    .add_i    (add),
    .shift_i  (shift),
    .mcand_i  (mcand),
    .mplier_i (mplier),
    .lsb_o    (m_bit),
    .low_o    (product)
  );
endmodule

// File: tb/tb_shift_add_mult.sv
module tb_shift_add_mult;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] mcand = '0;
  logic [3:0] mplier = '0;
  logic [7:0] product;
  logic       done;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  shift_add_mult dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mcand(mcand), .mplier(mplier), .product(product), .done(done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ones(input logic [3:0] v);
    int c = 0;
    for (int i = 0; i < 4; i++) c += v[i];
    return c;
  endfunction

  // Drive a start, then count negedges until done. Returns latency and product.
  task automatic run_op(input logic [3:0] a, input logic [3:0] b,
                        output int lat, output int prod);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    prod = product;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 product in reset", product, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 product after reset", product, 0);
  endtask

  task automatic t_trace;
    int exp_seq[8] = '{8'b00001011, 8'b11011011, 8'b01101101, 8'b00111101,
                       8'b10011110, 8'b01001111, 8'b00011111, 8'b10001111};
    @(negedge clk);
    mcand = 4'b1101; mplier = 4'b1011; start = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      start = 1'b0;
      if (i == 0) check("R2 load view", product, 8'b00001011);
      check("R9 trace value", product, exp_seq[i]);
      check("R9 done timing", done, (i == 7) ? 1 : 0);
    end
    @(negedge clk);
    check("R6 done one cycle", done, 0);
  endtask

  task automatic t_load;
    @(negedge clk);
    mcand = 4'hF; mplier = 4'b0110; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 upper cleared, multiplier in low bits", product, 8'b00000110);
    @(negedge clk);
    // M=0: shift only (R4)
    check("R4 shift without add", product, 8'b00000011);
    while (!done) @(negedge clk);
    check("R7 result 15*6", product, 90);
    @(negedge clk);
  endtask

  task automatic t_all_pairs;
    int lat, prod;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run_op(4'(a), 4'(b), lat, prod);
        check("R7 product", prod, a * b);
        check("R8 R5 latency", lat, 5 + ones(4'(b)));
        @(negedge clk);
        check("R6 done drops", done, 0);
      end
    end
  endtask

  task automatic t_start_mid_run;
    int lat = 1;
    @(negedge clk);
    mcand = 4'hB; mplier = 4'hF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    lat++;
    start = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R6 mid-run start latency", lat, 9);
    check("R6 mid-run start product", product, 11 * 15);
    @(negedge clk);
    check("R6 idle after done", done, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_trace();
    t_load();
    t_start_mid_run();
    t_all_pairs();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule